// File: doc/BRIEF.md
# Flash Chip-Select Window Register Bank

This block keeps one window register per flash chip select. Each register places the address range of one flash device inside a shared flash address window. The range is kept as a start and an exclusive end, both counted in 8 MB units. Software reads and writes the registers over a small word-addressed bus. Every write that would change a register is first checked against the windows already committed. A write is refused if it moves a protected boundary, leaves the flash window, or collides with another device's range. A refused write leaves the register as it was and raises a one-cycle reject pulse. A write whose start is not a multiple of its own length is still committed, but it raises a one-cycle warning pulse.

A combinational decoder runs beside the registers. It takes a flash-window address and, using the committed windows, returns a one-hot chip select, the byte offset inside the matching window, and a miss flag when no window covers the address.

Top module: `seg_window_bank`

## Requirements
- R1: A window register holds the exclusive end unit in bits 31:24 and the start unit in bits 23:16. A unit is address bits [30:23], so one unit is 8 MB. Bits 15:0 always read as zero, whatever was written to them.
- R2: The register for chip select n sits at word address 12+n (byte offset 0x30+4n). Other addresses read as zero and ignore writes. After reset, chip select n holds start 0x20+4n and end start+4 with the default parameters.
- R3: A write whose bits 31:16 equal the value the register already holds is a no-op. It raises neither reject nor warning.
- R4: The start of chip select 0 stays at the flash window base (unit 0x20). A write with any other start is rejected.
- R5: When the last-end lock parameter is set, which it is by default, a write to the last chip select (2) is rejected if it would change that chip select's default end (unit 0x2C).
- R6: A write is rejected if its end is at or below the window base (0x20) or its start is above base plus window size (0x30).
- R7: A write is rejected if its window overlaps the committed window of another chip select. Overlap means new_start < other_end and new_end > other_start. The chip select being written is not compared with itself.
- R8: A committed write with end > start and start mod (end - start) not zero raises the warning pulse. Reject and warning never pulse together.
- R9: A window with end <= start is empty. It never matches in the decoder and never overlaps another window, whether it is the new window or the committed one.
- R10: The decoder reports the lowest-numbered chip select whose non-empty window contains address bits [30:23]. It gives that select as one-hot, and the offset as the address minus start*8 MB. When no window matches, the one-hot output is zero and the miss flag is set.
- R11: A register update and its reject or warning pulse appear on the clock edge that samples the write, and each pulse lasts exactly one cycle. A rejected write leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| probe_addr | input | 31 | Flash-window address to decode |
| probe_cs | output | 3 | One-hot chip select of the matching window |
| probe_offset | output | 31 | Offset inside the matching window |
| probe_miss | output | 1 | No window contains probe_addr |
| wr_reject | output | 1 | One-cycle pulse: last write was refused |
| wr_warn | output | 1 | One-cycle pulse: last write committed misaligned |

## Verification
A wrong committed window shows up in the decoder outputs in the same cycle, once the probe address falls into the affected range. Because of this, the bench moves the probe address to a new random value on every clock and compares the decode against its own model of the windows. A bad legality decision shows up one edge after the write, in the reject or warning pulse. It also shows up later, because the register readback and the window decode no longer match the model from that point on. Random write storms cover every collision and boundary case long before the run ends.

// File: rtl/seg_window_pkg.sv
package seg_window_pkg;

  typedef struct packed {
    logic [7:0] win_end;
    logic [7:0] win_start;
  } seg_t;

  function automatic logic seg_empty(seg_t s);
    return s.win_end <= s.win_start;
  endfunction

  function automatic logic seg_collide(seg_t a, seg_t b);
    if (seg_empty(a) || seg_empty(b)) return 1'b0;
    return (a.win_start < b.win_end) && (a.win_end > b.win_start);
  endfunction

  function automatic logic seg_misaligned(seg_t s);
    logic [7:0] len;
    len = s.win_end - s.win_start;
    if (seg_empty(s)) return 1'b0;
    return (s.win_start % len) != 8'd0;
  endfunction

  function automatic logic [31:0] seg_to_word(seg_t s);
    return {s.win_end, s.win_start, 16'h0000};
  endfunction

endpackage

// File: rtl/seg_write_check.sv
module seg_write_check
  import seg_window_pkg::*;
#(
  parameter int NUM_CS        = 3,
  parameter int CS_W          = 2,
  parameter int WIN_BASE      = 8'h20,
  parameter int WIN_UNITS     = 16,
  parameter int LOCK_LAST_END = 1,
  parameter int LOCKED_END    = 8'h2C
) (
  input  logic [CS_W-1:0]          idx,
  input  seg_t                     cand,
  input  seg_t [NUM_CS-1:0]        cur,
  output logic                     bad_cs0,
  output logic                     bad_lock,
  output logic                     bad_range,
  output logic                     bad_overlap,
  output logic                     refuse,
  output logic                     misaligned
);
  localparam int WIN_TOP = WIN_BASE + WIN_UNITS;

  logic [NUM_CS-1:0] clash;

  generate
    for (genvar g = 0; g < NUM_CS; g++) begin : g_clash
      assign clash[g] = (idx != CS_W'(g)) && seg_collide(cand, cur[g]);
    end
  endgenerate

  always_comb begin
    bad_cs0     = (idx == '0) && (32'(cand.win_start) != WIN_BASE);
    bad_lock    = (LOCK_LAST_END != 0) && (idx == CS_W'(NUM_CS - 1)) &&
                  (32'(cand.win_end) != LOCKED_END);
    bad_range   = (32'(cand.win_end) <= WIN_BASE) || (32'(cand.win_start) > WIN_TOP);
    bad_overlap = |clash;
    refuse      = bad_cs0 | bad_lock | bad_range | bad_overlap;
    misaligned  = seg_misaligned(cand);
  end
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import seg_window_pkg::*;
#(
  parameter int NUM_CS = 3,
  parameter int AW     = 31,
  parameter int UNIT_SHIFT = 23
) (
  input  seg_t [NUM_CS-1:0] segs,
  input  logic [AW-1:0]     addr,
  output logic [NUM_CS-1:0] cs_onehot,
  output logic [AW-1:0]     offset,
  output logic              miss
);
  logic [7:0] unit;
  logic [NUM_CS-1:0] hit;

  assign unit = addr[UNIT_SHIFT +: 8];

  generate
    for (genvar g = 0; g < NUM_CS; g++) begin : g_hit
      assign hit[g] = !seg_empty(segs[g]) &&
                      (unit >= segs[g].win_start) && (unit < segs[g].win_end);
    end
  endgenerate

  always_comb begin
    cs_onehot = '0;
    offset    = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        cs_onehot = NUM_CS'(1) << i;
        offset    = addr - (AW'(segs[i].win_start) << UNIT_SHIFT);
      end
    end
    miss = (hit == '0);
  end
endmodule

// File: rtl/seg_window_bank.sv
module seg_window_bank
  import seg_window_pkg::*;
#(
  parameter int NUM_CS        = 3,
  parameter int BUS_AW        = 6,
  parameter int REG_BASE_WORD = 12,
  parameter int AW            = 31,
  parameter int WIN_BASE      = 8'h20,
  parameter int WIN_UNITS     = 16,
  parameter int DEF_UNITS     = 4,
  parameter int LOCK_LAST_END = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [AW-1:0]     probe_addr,
  output logic [NUM_CS-1:0] probe_cs,
  output logic [AW-1:0]     probe_offset,
  output logic              probe_miss,
  output logic              wr_reject,
  output logic              wr_warn
);
  localparam int CS_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int LOCKED_END = WIN_BASE + NUM_CS * DEF_UNITS;

  function automatic seg_t default_seg(int n);
    seg_t s;
    s.win_start = 8'(WIN_BASE + n * DEF_UNITS);
    s.win_end   = 8'(WIN_BASE + (n + 1) * DEF_UNITS);
    return s;
  endfunction

  seg_t [NUM_CS-1:0] seg_q;
  seg_t              cand;
  logic [BUS_AW-1:0] rel_addr;
  logic [CS_W-1:0]   wr_idx;
  logic              sel_hit;
  logic              sel_rd;

  // named internal events for the checker
  logic wr_same, wr_try, wr_commit;
  logic bad_cs0, bad_lock, bad_range, bad_overlap, refuse, misaligned;

  assign rel_addr = bus_addr - BUS_AW'(REG_BASE_WORD);
  assign wr_idx   = rel_addr[CS_W-1:0];
  assign sel_hit  = (32'(bus_addr) >= REG_BASE_WORD) &&
                    (32'(bus_addr) < REG_BASE_WORD + NUM_CS);
  assign cand     = seg_t'(bus_wdata[31:16]);

  assign wr_same   = bus_wr && sel_hit && (cand == seg_q[wr_idx]);
  assign wr_try    = bus_wr && sel_hit && !wr_same;
  assign wr_commit = wr_try && !refuse;

  seg_write_check #(
    .NUM_CS(NUM_CS), .CS_W(CS_W), .WIN_BASE(WIN_BASE), .WIN_UNITS(WIN_UNITS),
    .LOCK_LAST_END(LOCK_LAST_END), .LOCKED_END(LOCKED_END)
  ) u_check (
    .idx(wr_idx), .cand(cand), .cur(seg_q),
    .bad_cs0(bad_cs0), .bad_lock(bad_lock), .bad_range(bad_range),
    .bad_overlap(bad_overlap), .refuse(refuse), .misaligned(misaligned)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) seg_q[i] <= default_seg(i);
      wr_reject <= 1'b0;
      wr_warn   <= 1'b0;
    end else begin
      if (wr_commit) seg_q[wr_idx] <= cand;
      wr_reject <= wr_try && refuse;
      wr_warn   <= wr_commit && misaligned;
    end
  end

  assign sel_rd    = sel_hit;
  assign bus_rdata = sel_rd ? seg_to_word(seg_q[wr_idx]) : 32'h0;

  seg_decoder #(.NUM_CS(NUM_CS), .AW(AW), .UNIT_SHIFT(23)) u_decode (
    .segs(seg_q), .addr(probe_addr),
    .cs_onehot(probe_cs), .offset(probe_offset), .miss(probe_miss)
  );
endmodule

// File: rtl/seg_window_bank_chk.sv
module seg_window_bank_chk
  import seg_window_pkg::*;
#(
  parameter int NUM_CS   = 3,
  parameter int WIN_BASE = 8'h20
) (
  input logic              clk,
  input logic              rst_n,
  input seg_t [NUM_CS-1:0] seg_q,
  input logic              wr_same,
  input logic              wr_reject,
  input logic              wr_warn,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CS-1:0] probe_cs,
  input logic              probe_miss
);
  p_low_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[15:0] == 16'h0);

  p_noop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_same |=> (!wr_reject && !wr_warn));

  p_cs0_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(seg_q[0].win_start) == WIN_BASE);

  p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_reject && wr_warn));

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_cs) && (probe_miss == (probe_cs == '0)));

  p_reject_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> $stable(seg_q));
endmodule

bind seg_window_bank seg_window_bank_chk #(.NUM_CS(NUM_CS), .WIN_BASE(WIN_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .seg_q(seg_q), .wr_same(wr_same),
  .wr_reject(wr_reject), .wr_warn(wr_warn), .bus_rdata(bus_rdata),
  .probe_cs(probe_cs), .probe_miss(probe_miss)
);

// File: tb/seg_window_bank_test.sv
module seg_window_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCS  = 3;
  localparam int BASE = 'h20;
  localparam int TOP  = 'h30;
  localparam int LEND = 'h2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [30:0] probe_addr = '0;
  logic [2:0]  probe_cs;
  logic [30:0] probe_offset;
  logic        probe_miss, wr_reject, wr_warn;

  int checks = 0, errors = 0;
  int ms[NCS], me[NCS];
  bit exp_rej = 0, exp_warn = 0, live = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_window_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .probe_addr(probe_addr),
    .probe_cs(probe_cs), .probe_offset(probe_offset), .probe_miss(probe_miss),
    .wr_reject(wr_reject), .wr_warn(wr_warn)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit empty_w(int s, int e);
    return e <= s;
  endfunction

  // per-cycle comparison of flags (R11) and decoder (R10, R9)
  always @(negedge clk) begin
    if (live) begin
      int a, u, hit;
      check(wr_reject == exp_rej, "R11 reject pulse", wr_reject, exp_rej);
      check(wr_warn == exp_warn, "R8 warn pulse", wr_warn, exp_warn);
      a = int'(probe_addr); u = a >> 23; hit = -1;
      for (int i = NCS - 1; i >= 0; i--)
        if (!empty_w(ms[i], me[i]) && u >= ms[i] && u < me[i]) hit = i;
      if (hit < 0) begin
        check(probe_miss && probe_cs == 0, "R10 miss", {probe_miss, probe_cs}, 4'b1000);
      end else begin
        check(!probe_miss && probe_cs == 3'(1 << hit), "R10 select", probe_cs, 1 << hit);
        check(int'(probe_offset) == a - (ms[hit] << 23), "R10 offset",
              probe_offset, a - (ms[hit] << 23));
      end
      probe_addr = 31'(((28 + $urandom % 24) << 23) | ($urandom & 32'h7FFFFF));
    end
  end

  task automatic wr(int idx, int s, int e, int low);
    int word;
    bit rej, warn, same;
    word = ((e & 'hFF) << 24) | ((s & 'hFF) << 16) | (low & 'hFFFF);
    @(negedge clk);
    bus_wr = 1; bus_addr = 6'(12 + idx); bus_wdata = word;
    same = (idx < NCS) && ms[idx] == s && me[idx] == e;
    rej = 0; warn = 0;
    if (idx < NCS && !same) begin
      if (idx == 0 && s != BASE) rej = 1;
      if (idx == NCS - 1 && e != LEND) rej = 1;
      if (e <= BASE || s > TOP) rej = 1;
      for (int j = 0; j < NCS; j++)
        if (j != idx && !empty_w(s, e) && !empty_w(ms[j], me[j]) &&
            s < me[j] && e > ms[j]) rej = 1;
      warn = !rej && !empty_w(s, e) && (s % (e - s)) != 0;
    end
    @(posedge clk); #1;
    exp_rej = rej; exp_warn = warn;
    if (idx < NCS && !same && !rej) begin ms[idx] = s; me[idx] = e; end
    @(negedge clk);
    bus_wr = 0;
    @(posedge clk); #1;
    exp_rej = 0; exp_warn = 0;
  endtask

  task automatic rd(int idx, string req);
    int exp;
    @(negedge clk);
    bus_addr = 6'(12 + idx); #1;
    exp = (idx < NCS) ? ((me[idx] << 24) | (ms[idx] << 16)) : 0;
    check(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  task automatic wr_chk(int idx, int s, int e, bit rej, bit warn, string req);
    wr(idx, s, e, 'hBEEF);
    check(exp_rej == 0, req, rej, rej);
    rd(idx, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCS; i++) begin ms[i] = BASE + 4 * i; me[i] = ms[i] + 4; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1; live = 1;
    // R2: reset defaults, R1 encoding
    for (int i = 0; i < NCS; i++) rd(i, "R2 reset value");
    rd(5, "R2 unmapped reads zero");
    // R3: same value, low bits differ -> no-op
    wr(1, 'h24, 'h28, 'h1234); rd(1, "R3 no-op keeps value");
    // R4: cs0 start move rejected
    wr(0, 'h21, 'h24, 0); rd(0, "R4 cs0 start fixed");
    // cs0 shrink accepted, R1 low bits read zero
    wr(0, 'h20, 'h22, 'hFFFF); rd(0, "R1 low bits zero");
    // R7: overlap with cs0
    wr(1, 'h21, 'h24, 0); rd(1, "R7 overlap refused");
    // R6: range edges
    wr(1, 'h1C, 'h20, 0); rd(1, "R6 end at base refused");
    wr(1, 'h31, 'h34, 0); rd(1, "R6 start above top refused");
    wr(1, 'h30, 'h31, 0); rd(1, "R6 start at top accepted");
    // R8: misaligned committed with warning
    wr(1, 'h25, 'h27, 0); rd(1, "R8 misaligned committed");
    // R5: last end locked
    wr(2, 'h28, 'h2D, 0); rd(2, "R5 last end locked");
    wr(2, 'h29, 'h2C, 0); rd(2, "R5 start change allowed");
    // R9: empty window, then another window may cover its range
    wr(1, 'h26, 'h26, 0); rd(1, "R9 empty committed");
    wr(2, 'h22, 'h2C, 0); rd(2, "R9 empty does not overlap");
    // write to non-window address: ignored (R2)
    wr(7, 'h20, 'h30, 0); for (int i = 0; i < NCS; i++) rd(i, "R2 stray write ignored");
    // random storm
    for (int n = 0; n < 600; n++) begin
      int c, s, e;
      c = $urandom % NCS;
      s = 'h1C + $urandom % 24; e = 'h1C + $urandom % 24;
      if (c == 0 && ($urandom % 2)) s = BASE;
      if (c == NCS - 1 && ($urandom % 2)) e = LEND;
      if ($urandom % 8 == 0) begin s = ms[c]; e = me[c]; end
      wr(c, s, e, int'($urandom));
      rd(c, "R11 register after write");
    end
    repeat (50) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule